// File: doc/BRIEF.md
# Thermal Throttle Hysteresis Controller

This block turns the raw counts of an on-die temperature sensor into frequency-throttling requests for an external voltage and frequency sequencer. The sensor's counts run opposite to temperature: a larger count means a cooler die. A 32-bit calibration word gives two fixed points, a count taken at room temperature (25 °C) and a count taken at a hot temperature. The block interpolates linearly between them. It derives two comparison counts from a throttle temperature: a trigger count, below which the die is too hot, and a release count, above which it has cooled enough. The gap between the two gives hysteresis.

Software may reprogram the throttle temperature, given in deci-Kelvin. The block captures sensor samples only when they are flagged valid. Once it is calibrated and has seen a valid non-zero count, a check timer runs. At every period the timer compares the last captured count with the two thresholds and issues at most one single-cycle go-slow or go-fast pulse. The block also reports the last count converted to deci-Celsius.

Top module: `thermo_throttle_ctrl`

## Requirements
- R1: On `cal_load` the calibration word is decoded as follows: room count in bits [31:20], hot count in bits [19:8], hot temperature in whole °C in bits [7:0]. The hot temperature in deci-Celsius is H = bits[7:0]×10. The trigger count becomes C(H−100) and the release count becomes C(H−150). `cal_load` wins over a throttle write in the same cycle.
- R2: C(T) = (room−hot)×(H−T)/(H−250) + hot. The arithmetic is signed with integer division truncating toward zero, and the result is clamped to 0..4095.
- R3: A throttle write with `thr_dk` ≥ 2732 sets T = `thr_dk`−2732, the trigger count to C(T) and the release count to C(T−100). A write with `thr_dk` below 2732 leaves both counts unchanged.
- R4: A sample is captured only when `sample_valid` is high. `temp_dc` = H − (cnt−hot)×(H−250)/(room−hot), computed on the last captured count, and it is visible the cycle after capture.
- R5: `monitoring` rises, and pulses become possible, only once calibration is loaded and a valid sample with a non-zero count has been captured. A valid zero count does not arm the block.
- R6: While monitoring, a check fires every `CHECK_CYCLES` clock cycles. Its result appears as a one-cycle pulse on the following cycle.
- R7: At a check, a count below the trigger count pulses `go_slow` unless `freq_at_min` is high. A count above the release count pulses `go_fast` unless `freq_at_max` is high. A count equal to either threshold, or between them, pulses neither. The two pulses are never high together.
- R8: After reset, both pulses, `monitoring`, `trig_cnt` and `rel_cnt` are 0.
- R9: If H equals 250, both threshold counts equal the hot count. If the room and hot counts are equal, `temp_dc` equals H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_load | input | 1 | Load calibration word and default thresholds |
| cal_word | input | 32 | Packed calibration points |
| thr_wr | input | 1 | Throttle temperature write strobe |
| thr_dk | input | 16 | Throttle temperature in deci-Kelvin |
| sample_valid | input | 1 | Sensor sample valid flag |
| sample_cnt | input | 12 | Sensor count (higher is cooler) |
| freq_at_min | input | 1 | Sequencer already at minimum frequency |
| freq_at_max | input | 1 | Sequencer already at maximum frequency |
| go_slow | output | 1 | Request to lower frequency (pulse) |
| go_fast | output | 1 | Request to raise frequency (pulse) |
| monitoring | output | 1 | Periodic checks are running |
| trig_cnt | output | 12 | Current trigger count |
| rel_cnt | output | 12 | Current release count |
| temp_dc | output | 16 | Last captured temperature, signed deci-Celsius |

## Verification
A wrong threshold shows on `trig_cnt`/`rel_cnt` one cycle after the load or write. At the next check it also shows as a missing or wrong pulse for counts placed exactly on and one step beside each threshold. A capture register that takes unflagged samples changes `temp_dc` on the very next cycle. A check timer that arms early, or that runs at the wrong rate, shows as a pulse before `monitoring` rises or as a gap between successive pulses other than `CHECK_CYCLES`.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int CNT_W      = 12;
  localparam int TEMP_W     = 16;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int ROOM_LSB   = 20;
  localparam int HOT_LSB    = 8;
  localparam int HOTT_W     = 8;
  localparam int ROOM_DC    = 250;
  localparam int ZERO_C_DK  = 2732;
  localparam int TMAX       = (1 << (TEMP_W - 1)) - 1;
  localparam int TMIN       = -(1 << (TEMP_W - 1));

  // temperature (deci-Celsius) -> sensor count, clamped to the count range
  function automatic logic [CNT_W-1:0] count_from_temp(int room, int hot, int hot_dc, int t);
    int den;
    int r;
    den = hot_dc - ROOM_DC;
    if (den == 0) r = hot;
    else          r = (room - hot) * (hot_dc - t) / den + hot;
    if (r < 0)        r = 0;
    if (r > CNT_MAX)  r = CNT_MAX;
    return CNT_W'(r);
  endfunction

  // sensor count -> temperature (deci-Celsius), clamped to the output width
  function automatic logic signed [TEMP_W-1:0] temp_from_count(int room, int hot, int hot_dc, int cnt);
    int den;
    int r;
    den = room - hot;
    if (den == 0) r = hot_dc;
    else          r = hot_dc - (cnt - hot) * (hot_dc - ROOM_DC) / den;
    if (r > TMAX) r = TMAX;
    if (r < TMIN) r = TMIN;
    return TEMP_W'(r);
  endfunction
endpackage

// File: rtl/thermo_thresh.sv
module thermo_thresh
  import thermo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_load,
  input  logic [31:0]       cal_word,
  input  logic              thr_wr,
  input  logic [15:0]       thr_dk,
  output logic [CNT_W-1:0]  room_cnt,
  output logic [CNT_W-1:0]  hot_cnt,
  output logic [15:0]       hot_dc,
  output logic [CNT_W-1:0]  trig_cnt,
  output logic [CNT_W-1:0]  rel_cnt,
  output logic              cal_ok,
  output logic              thr_accept
);
  logic [CNT_W-1:0] c_room, c_hot;
  logic [15:0]      c_hot_dc;
  int               thr_dc;

  assign c_room     = cal_word[ROOM_LSB +: CNT_W];
  assign c_hot      = cal_word[HOT_LSB +: CNT_W];
  assign c_hot_dc   = 16'(cal_word[HOTT_W-1:0]) * 16'd10;
  assign thr_accept = thr_wr && (int'(thr_dk) >= ZERO_C_DK);
  assign thr_dc     = int'(thr_dk) - ZERO_C_DK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      room_cnt <= '0;
      hot_cnt  <= '0;
      hot_dc   <= '0;
      trig_cnt <= '0;
      rel_cnt  <= '0;
      cal_ok   <= 1'b0;
    end else if (cal_load) begin
      room_cnt <= c_room;
      hot_cnt  <= c_hot;
      hot_dc   <= c_hot_dc;
      trig_cnt <= count_from_temp(int'(c_room), int'(c_hot), int'(c_hot_dc), int'(c_hot_dc) - 100);
      rel_cnt  <= count_from_temp(int'(c_room), int'(c_hot), int'(c_hot_dc), int'(c_hot_dc) - 150);
      cal_ok   <= 1'b1;
    end else if (thr_accept) begin
      trig_cnt <= count_from_temp(int'(room_cnt), int'(hot_cnt), int'(hot_dc), thr_dc);
      rel_cnt  <= count_from_temp(int'(room_cnt), int'(hot_cnt), int'(hot_dc), thr_dc - 100);
    end
  end
endmodule

// File: rtl/thermo_sample.sv
module thermo_sample
  import thermo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic [CNT_W-1:0] sample_cnt,
  output logic [CNT_W-1:0] last_cnt,
  output logic             armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cnt <= '0;
      armed    <= 1'b0;
    end else if (sample_valid) begin
      last_cnt <= sample_cnt;
      if (sample_cnt != '0) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/thermo_decide.sv
module thermo_decide
  import thermo_pkg::*;
#(
  parameter int CHECK_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] last_cnt,
  input  logic [CNT_W-1:0] trig_cnt,
  input  logic [CNT_W-1:0] rel_cnt,
  input  logic             at_min,
  input  logic             at_max,
  output logic             check_tick,
  output logic             go_slow,
  output logic             go_fast
);
  localparam int TW = (CHECK_CYCLES > 2) ? $clog2(CHECK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CHECK_CYCLES - 1);

  logic [TW-1:0] phase;
  logic          too_hot, cool_enough;

  assign check_tick  = en && (phase == LAST);
  assign too_hot     = last_cnt < trig_cnt;
  assign cool_enough = last_cnt > rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)      phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_slow <= 1'b0;
      go_fast <= 1'b0;
    end else begin
      go_slow <= check_tick && too_hot && !at_min;
      go_fast <= check_tick && !too_hot && cool_enough && !at_max;
    end
  end
endmodule

// File: rtl/thermo_throttle_ctrl.sv
module thermo_throttle_ctrl
  import thermo_pkg::*;
#(
  parameter int CHECK_CYCLES = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cal_load,
  input  logic [31:0]              cal_word,
  input  logic                     thr_wr,
  input  logic [15:0]              thr_dk,
  input  logic                     sample_valid,
  input  logic [11:0]              sample_cnt,
  input  logic                     freq_at_min,
  input  logic                     freq_at_max,
  output logic                     go_slow,
  output logic                     go_fast,
  output logic                     monitoring,
  output logic [11:0]              trig_cnt,
  output logic [11:0]              rel_cnt,
  output logic signed [15:0]       temp_dc
);
  logic [CNT_W-1:0] room_cnt, hot_cnt, last_cnt;
  logic [15:0]      hot_dc;
  logic             cal_ok, armed, thr_accept, check_tick;

  thermo_thresh u_thresh (
    .clk, .rst_n, .cal_load, .cal_word, .thr_wr, .thr_dk,
    .room_cnt, .hot_cnt, .hot_dc, .trig_cnt, .rel_cnt, .cal_ok, .thr_accept
  );

  thermo_sample u_sample (
    .clk, .rst_n, .sample_valid, .sample_cnt, .last_cnt, .armed
  );

  assign monitoring = cal_ok && armed;

  thermo_decide #(.CHECK_CYCLES(CHECK_CYCLES)) u_decide (
    .clk, .rst_n, .en(monitoring), .last_cnt, .trig_cnt, .rel_cnt,
    .at_min(freq_at_min), .at_max(freq_at_max), .check_tick, .go_slow, .go_fast
  );

  assign temp_dc = temp_from_count(int'(room_cnt), int'(hot_cnt), int'(hot_dc), int'(last_cnt));
endmodule

// File: rtl/thermo_throttle_chk.sv
module thermo_throttle_chk #(
  parameter int CHECK_CYCLES = 1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cal_load,
  input logic               thr_wr,
  input logic [15:0]        thr_dk,
  input logic               sample_valid,
  input logic               freq_at_min,
  input logic               freq_at_max,
  input logic               go_slow,
  input logic               go_fast,
  input logic               monitoring,
  input logic               check_tick,
  input logic [11:0]        trig_cnt,
  input logic [11:0]        rel_cnt,
  input logic signed [15:0] temp_dc
);
  localparam int PW = $clog2(CHECK_CYCLES + 1);
  logic [PW-1:0] gap;
  logic          seen;
  logic          pulse;

  assign pulse = go_slow || go_fast;

  // cycles since the last pulse, modulo the check period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (pulse) begin
      gap  <= PW'(1);
      seen <= 1'b1;
    end else if (gap == PW'(CHECK_CYCLES - 1)) begin
      gap  <= '0;
    end else begin
      gap  <= gap + 1'b1;
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(go_slow && go_fast));
  p_slowmin_r7: assert property (@(posedge clk) disable iff (!rst_n) go_slow |-> $past(!freq_at_min));
  p_fastmax_r7: assert property (@(posedge clk) disable iff (!rst_n) go_fast |-> $past(!freq_at_max));
  p_armed_r5: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $past(monitoring));
  p_tick_r6: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $past(check_tick));
  p_period_r6: assert property (@(posedge clk) disable iff (!rst_n) (pulse && seen) |-> (gap == '0));
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && thr_dk < 16'd2732 && !cal_load) |=> ($stable(trig_cnt) && $stable(rel_cnt)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !cal_load) |=> $stable(temp_dc));
endmodule

bind thermo_throttle_ctrl thermo_throttle_chk #(.CHECK_CYCLES(CHECK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .thr_wr(thr_wr), .thr_dk(thr_dk),
  .sample_valid(sample_valid), .freq_at_min(freq_at_min), .freq_at_max(freq_at_max),
  .go_slow(go_slow), .go_fast(go_fast), .monitoring(monitoring), .check_tick(check_tick),
  .trig_cnt(trig_cnt), .rel_cnt(rel_cnt), .temp_dc(temp_dc)
);

// File: tb/test_thermo_throttle_ctrl.sv
module test_thermo_throttle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCHK       = 16;
  localparam int WATCHDOG   = 20000;

  // calibration: room 1800, hot 1200, hot 105 C (H = 1050)
  localparam logic [31:0] CAL_A = 32'h7084B069;

  typedef struct packed {
    logic [11:0] cnt;
    logic        at_min;
    logic        at_max;
    logic        exp_slow;
    logic        exp_fast;
    logic [15:0] exp_temp;
  } vec_t;

  // thresholds under CAL_A defaults: trigger 1275, release 1312
  localparam vec_t VECS [9] = '{
    '{12'd1200, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1050},
    '{12'd1274, 1'b0, 1'b0, 1'b1, 1'b0, 16'd952},
    '{12'd1275, 1'b0, 1'b0, 1'b0, 1'b0, 16'd950},
    '{12'd1312, 1'b0, 1'b0, 1'b0, 1'b0, 16'd901},
    '{12'd1313, 1'b0, 1'b0, 1'b0, 1'b1, 16'd900},
    '{12'd1800, 1'b0, 1'b0, 1'b0, 1'b1, 16'd250},
    '{12'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1050},
    '{12'd1800, 1'b0, 1'b1, 1'b0, 1'b0, 16'd250},
    '{12'd1290, 1'b1, 1'b1, 1'b0, 1'b0, 16'd930}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_load = 1'b0;
  logic [31:0] cal_word = '0;
  logic thr_wr = 1'b0;
  logic [15:0] thr_dk = '0;
  logic sample_valid = 1'b0;
  logic [11:0] sample_cnt = '0;
  logic freq_at_min = 1'b0;
  logic freq_at_max = 1'b0;
  logic go_slow, go_fast, monitoring;
  logic [11:0] trig_cnt, rel_cnt;
  logic signed [15:0] temp_dc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_throttle_ctrl #(.CHECK_CYCLES(NCHK)) i_thermo_throttle_ctrl (
    .clk, .rst_n, .cal_load, .cal_word, .thr_wr, .thr_dk, .sample_valid, .sample_cnt,
    .freq_at_min, .freq_at_max, .go_slow, .go_fast, .monitoring, .trig_cnt, .rel_cnt, .temp_dc
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cal(input logic [31:0] w);
    @(negedge clk); cal_word = w; cal_load = 1'b1;
    @(negedge clk); cal_load = 1'b0;
  endtask

  task automatic write_thr(input logic [15:0] v);
    @(negedge clk); thr_dk = v; thr_wr = 1'b1;
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic put_sample(input logic [11:0] c, input logic v);
    @(negedge clk); sample_cnt = c; sample_valid = v;
    @(negedge clk); sample_valid = 1'b0;
  endtask

  // observe the pulses over a span longer than one check period
  task automatic watch(output int n_slow, output int n_fast, output int n_both);
    n_slow = 0; n_fast = 0; n_both = 0;
    for (int i = 0; i < NCHK + 2; i++) begin
      @(negedge clk);
      if (go_slow) n_slow++;
      if (go_fast) n_fast++;
      if (go_slow && go_fast) n_both++;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ns, nf, nb, gap;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 go_slow", int'(go_slow), 0);
    check("R8 go_fast", int'(go_fast), 0);
    check("R8 monitoring", int'(monitoring), 0);
    check("R8 trig_cnt", int'(trig_cnt), 0);
    check("R8 rel_cnt", int'(rel_cnt), 0);
    rst_n = 1'b1;

    // R5: valid samples without calibration do not arm
    put_sample(12'd1500, 1'b1);
    check("R5 no cal no monitoring", int'(monitoring), 0);

    // R1/R2: calibration defaults
    load_cal(CAL_A);
    check("R1 trigger from cal", int'(trig_cnt), 1275);
    check("R1 release from cal", int'(rel_cnt), 1312);

    // R5: valid zero count does not keep arming; reset to clear the earlier capture
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    load_cal(CAL_A);
    put_sample(12'd0, 1'b1);
    check("R5 zero count", int'(monitoring), 0);
    check("R4 temp of zero count", int'(temp_dc), 2650);
    watch(ns, nf, nb);
    check("R5 no pulses before arming", ns + nf, 0);
    // R4: unflagged sample ignored
    put_sample(12'd1800, 1'b0);
    check("R4 invalid sample ignored", int'(temp_dc), 2650);
    check("R5 invalid sample does not arm", int'(monitoring), 0);
    put_sample(12'd1200, 1'b1);
    check("R5 armed", int'(monitoring), 1);
    check("R4 temp after capture", int'(temp_dc), 1050);

    // R7/R4: table of decisions
    foreach (VECS[k]) begin
      @(negedge clk);
      freq_at_min = VECS[k].at_min;
      freq_at_max = VECS[k].at_max;
      put_sample(VECS[k].cnt, 1'b1);
      check("R4 temp readout", int'(temp_dc), int'($signed(VECS[k].exp_temp)));
      watch(ns, nf, nb);
      check("R7 go_slow seen", int'(ns > 0), int'(VECS[k].exp_slow));
      check("R7 go_fast seen", int'(nf > 0), int'(VECS[k].exp_fast));
      check("R7 exclusive", nb, 0);
    end
    freq_at_min = 1'b0; freq_at_max = 1'b0;

    // R3: throttle writes
    write_thr(16'd3732);
    check("R3 trigger at 100.0 C", int'(trig_cnt), 1237);
    check("R3 release at 90.0 C", int'(rel_cnt), 1312);
    write_thr(16'd2731);
    check("R3 reject below 0 C trig", int'(trig_cnt), 1237);
    check("R3 reject below 0 C rel", int'(rel_cnt), 1312);
    write_thr(16'd2732);
    check("R3 accept 0 C trig", int'(trig_cnt), 1987);
    check("R3 accept 0 C rel", int'(rel_cnt), 2062);

    // R6: pulse period
    put_sample(12'd4000, 1'b1);
    gap = 0;
    for (int i = 0; i < 3 * NCHK && !go_fast; i++) @(negedge clk);
    check("R6 first pulse", int'(go_fast), 1);
    for (int i = 0; i < 3 * NCHK; i++) begin
      @(negedge clk);
      gap++;
      if (go_fast) break;
    end
    check("R6 pulse spacing", gap, NCHK);

    // R9: degenerate calibration points
    load_cal(32'h7084B019); // room 1800, hot 1200, hot 25 C
    check("R9 trig equals hot", int'(trig_cnt), 1200);
    check("R9 rel equals hot", int'(rel_cnt), 1200);
    load_cal(32'h3E83E850); // room 1000, hot 1000, hot 80 C
    put_sample(12'd1500, 1'b1);
    check("R9 temp equals hot temp", int'(temp_dc), 800);

    // R2: clamp to the count range
    load_cal(32'hFA00641E); // room 4000, hot 100, hot 30 C
    check("R2 trigger clamped", int'(trig_cnt), 4095);
    check("R2 release clamped", int'(rel_cnt), 4095);
    // R1: cal_load wins over a same-cycle throttle write
    @(negedge clk); cal_word = CAL_A; cal_load = 1'b1; thr_dk = 16'd3732; thr_wr = 1'b1;
    @(negedge clk); cal_load = 1'b0; thr_wr = 1'b0;
    check("R1 cal priority trig", int'(trig_cnt), 1275);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule